// File: doc/BRIEF.md
# Line Return Buffer Pair

This block keeps one cache line per access pipeline, normally one pipeline for loads and stores and one for loads only. Each buffer holds the most recent line delivered for a tagged request. Consumers then fetch data with a combinational lookup that gives a pipeline, a byte address and the request number they are waiting for. A lookup hits only if the buffer holds a live line that covers that byte and was filled for that same request. On a hit the block returns the aligned 32-bit word that contains the byte.

The buffers are snooped so they never return stale data. A store or preload to a line drops every buffer, on either pipeline, that holds that line. A whole-cache invalidate drops both buffers. Next to each buffer sits a flush-status record: a line address and a request number. It answers a "has this request's line been flushed" lookup with the same range and request-number rule.

Fills, snoops and record updates take effect on the clock edge. Lookups read the registered state with no delay.

Top module: `line_return_buffer`

## Requirements
- R1: After reset every buffer and every flush record is invalid, so every data lookup and every flushed lookup misses.
- R2: A fill on pipeline p stores the request number, the line data and the fill address with its low log2(LINE_BYTES) bits cleared. The buffer becomes valid from the next clock edge.
- R3: A data lookup hits only when the selected buffer is valid, its request number equals the lookup request number, and base <= address < base + LINE_BYTES. Lines at the top of the address space are included.
- R4: On a hit, q_word is the 32-bit word at line bits [32k+31:32k], where k = (address mod LINE_BYTES) div 4.
- R5: A snoop (a store or preload) clears the valid bit of every buffer, on both pipelines, whose base equals the snoop address with its offset bits cleared. Buffers holding other lines are left unchanged.
- R6: Invalidate-all clears the valid bits of both buffers unconditionally. It leaves the flush records unchanged.
- R7: When a fill and a snoop or invalidate-all reach the same buffer in the same cycle, the fill wins and the buffer holds the new line.
- R8: flush_set on pipeline p loads that pipeline's flush record with valid, the line-aligned address and the request number. flush_clr clears the record, and set wins over clear in the same cycle. The flushed lookup follows the same rule as R3.
- R9: q_pipe selects which pipeline's buffer and flush record a lookup uses. The other pipeline's state has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | NUM_PIPES | Per-pipeline line fill strobe |
| fill_addr | input | NUM_PIPES*ADDR_W | Per-pipeline fill request address |
| fill_reqno | input | NUM_PIPES*REQ_W | Per-pipeline fill request number |
| fill_data | input | NUM_PIPES*LINE_BYTES*8 | Per-pipeline line data |
| snoop_en | input | 1 | Store or preload touching a line |
| snoop_addr | input | ADDR_W | Address of that store or preload |
| inv_all | input | 1 | Whole-cache invalidate |
| flush_set | input | NUM_PIPES | Load flush record |
| flush_clr | input | NUM_PIPES | Clear flush record |
| flush_addr | input | NUM_PIPES*ADDR_W | Flushed line address |
| flush_reqno | input | NUM_PIPES*REQ_W | Flushed request number |
| q_pipe | input | PSEL_W | Lookup pipeline select |
| q_addr | input | ADDR_W | Lookup byte address |
| q_reqno | input | REQ_W | Lookup request number |
| q_hit | output | 1 | Data available in the buffer |
| q_word | output | 32 | Word containing the byte |
| q_flushed | output | 1 | Flush record matches |

## Verification
After every state change, the bench sweeps a small configuration exhaustively: every byte address, every request number and both pipelines. Each sweep compares the hit, word and flushed outputs with values worked out arithmetically. Different tags tell a request-number mismatch apart from an address miss. Addresses just below and just above a line tell an off-by-one range apart from a correct one. A line at the very top of the address space shows whether the range comparison wraps. The stimulus also includes snoops that hit one pipeline, snoops that hit both, and a snoop to an unrelated line. These show whether the snoop compares line addresses and whether it reaches both buffers. Fills that coincide with snoops and with invalidate-all check that the fill takes priority.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 32;
endpackage

// File: rtl/lrb_match.sv
module lrb_match #(
    parameter int ADDR_W     = 32,
    parameter int REQ_W      = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic              rec_vld,
    input  logic [ADDR_W-1:0] rec_base,
    input  logic [REQ_W-1:0]  rec_tag,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [REQ_W-1:0]  q_tag,
    output logic              hit
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [ADDR_W:0] lo_ext, hi_ext, addr_ext;

    always_comb begin
        lo_ext   = {1'b0, rec_base};
        hi_ext   = lo_ext + (ADDR_W+1)'(LINE_BYTES);
        addr_ext = {1'b0, q_addr};
        hit      = rec_vld && (rec_tag == q_tag) &&
                   (addr_ext >= lo_ext) && (addr_ext < hi_ext);
    end

    // a range hit must land in the same aligned line as the record base
    always_comb begin
        if (hit) begin
            AST_HIT_SAME_LINE: assert ({q_addr[ADDR_W-1:OFF_W], OFF_W'(0)} == rec_base); // R3
        end
    end
endmodule

// File: rtl/lrb_entry.sv
module lrb_entry #(
    parameter int ADDR_W     = 32,
    parameter int REQ_W      = 8,
    parameter int LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_en,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [REQ_W-1:0]        fill_tag,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    input  logic                    snoop_en,
    input  logic [ADDR_W-1:0]       snoop_addr,
    input  logic                    inv_all,
    input  logic                    flush_set,
    input  logic                    flush_clr,
    input  logic [ADDR_W-1:0]       flush_addr,
    input  logic [REQ_W-1:0]        flush_tag,
    output logic                    buf_vld,
    output logic [ADDR_W-1:0]       buf_base,
    output logic [REQ_W-1:0]        buf_tag,
    output logic [LINE_BYTES*8-1:0] buf_line,
    output logic                    fl_vld,
    output logic [ADDR_W-1:0]       fl_base,
    output logic [REQ_W-1:0]        fl_tag
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] base;
        logic [REQ_W-1:0]  tag;
        logic [LINE_W-1:0] line;
        logic              fvld;
        logic [ADDR_W-1:0] fbase;
        logic [REQ_W-1:0]  ftag;
    } entry_t;

    entry_t st_d, st_q;
    logic [ADDR_W-1:0] fill_base_d, snoop_base_d, flush_base_d;
    logic              snoop_match_d;

    always_comb begin
        fill_base_d   = {fill_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
        snoop_base_d  = {snoop_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
        flush_base_d  = {flush_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
        snoop_match_d = snoop_en && st_q.vld && (st_q.base == snoop_base_d);
        st_d = st_q;
        if (inv_all || snoop_match_d) begin
            st_d.vld = 1'b0;
        end
        if (fill_en) begin
            st_d.vld  = 1'b1;
            st_d.base = fill_base_d;
            st_d.tag  = fill_tag;
            st_d.line = fill_line;
        end
        if (flush_clr) begin
            st_d.fvld = 1'b0;
        end
        if (flush_set) begin
            st_d.fvld  = 1'b1;
            st_d.fbase = flush_base_d;
            st_d.ftag  = flush_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_vld  = st_q.vld;
    assign buf_base = st_q.base;
    assign buf_tag  = st_q.tag;
    assign buf_line = st_q.line;
    assign fl_vld   = st_q.fvld;
    assign fl_base  = st_q.fbase;
    assign fl_tag   = st_q.ftag;

    AST_FILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> buf_vld && buf_tag == $past(fill_tag) &&
                    buf_base == {$past(fill_addr[ADDR_W-1:OFF_W]), OFF_W'(0)}); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> !$rose(buf_vld)); // R2
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_vld |-> buf_base[OFF_W-1:0] == '0); // R2
    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_en && !fill_en && buf_vld &&
        buf_base[ADDR_W-1:OFF_W] == snoop_addr[ADDR_W-1:OFF_W] |=> !buf_vld); // R5
    AST_INV_ALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all && !fill_en |=> !buf_vld); // R6
    AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && (snoop_en || inv_all) |=> buf_vld); // R7
    AST_FLUSH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_set |=> fl_vld && fl_tag == $past(flush_tag)); // R8
    AST_FLUSH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_set && !flush_clr |=> $stable(fl_vld)); // R6
endmodule

// File: rtl/line_return_buffer.sv
module line_return_buffer #(
    parameter int NUM_PIPES  = 2,
    parameter int ADDR_W     = 32,
    parameter int REQ_W      = 8,
    parameter int LINE_BYTES = 32,
    localparam int PSEL_W    = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PIPES-1:0]              fill_en,
    input  logic [NUM_PIPES*ADDR_W-1:0]       fill_addr,
    input  logic [NUM_PIPES*REQ_W-1:0]        fill_reqno,
    input  logic [NUM_PIPES*LINE_BYTES*8-1:0] fill_data,
    input  logic                              snoop_en,
    input  logic [ADDR_W-1:0]                 snoop_addr,
    input  logic                              inv_all,
    input  logic [NUM_PIPES-1:0]              flush_set,
    input  logic [NUM_PIPES-1:0]              flush_clr,
    input  logic [NUM_PIPES*ADDR_W-1:0]       flush_addr,
    input  logic [NUM_PIPES*REQ_W-1:0]        flush_reqno,
    input  logic [PSEL_W-1:0]                 q_pipe,
    input  logic [ADDR_W-1:0]                 q_addr,
    input  logic [REQ_W-1:0]                  q_reqno,
    output logic                              q_hit,
    output logic [lrb_pkg::WORD_W-1:0]        q_word,
    output logic                              q_flushed
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = OFF_W - $clog2(lrb_pkg::WORD_BYTES);

    logic [NUM_PIPES-1:0] data_hit, flush_hit;
    logic [LINE_W-1:0]    line_q [NUM_PIPES];
    logic [LINE_W-1:0]    sel_line;
    logic [IDX_W-1:0]     word_idx;

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        logic              b_vld, f_vld;
        logic [ADDR_W-1:0] b_base, f_base;
        logic [REQ_W-1:0]  b_tag, f_tag;

        lrb_entry #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .LINE_BYTES(LINE_BYTES)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_en    (fill_en[p]),
            .fill_addr  (fill_addr[p*ADDR_W +: ADDR_W]),
            .fill_tag   (fill_reqno[p*REQ_W +: REQ_W]),
            .fill_line  (fill_data[p*LINE_W +: LINE_W]),
            .snoop_en   (snoop_en),
            .snoop_addr (snoop_addr),
            .inv_all    (inv_all),
            .flush_set  (flush_set[p]),
            .flush_clr  (flush_clr[p]),
            .flush_addr (flush_addr[p*ADDR_W +: ADDR_W]),
            .flush_tag  (flush_reqno[p*REQ_W +: REQ_W]),
            .buf_vld    (b_vld),
            .buf_base   (b_base),
            .buf_tag    (b_tag),
            .buf_line   (line_q[p]),
            .fl_vld     (f_vld),
            .fl_base    (f_base),
            .fl_tag     (f_tag)
        );

        lrb_match #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .LINE_BYTES(LINE_BYTES)) u_data_match (
            .rec_vld  (b_vld),
            .rec_base (b_base),
            .rec_tag  (b_tag),
            .q_addr   (q_addr),
            .q_tag    (q_reqno),
            .hit      (data_hit[p])
        );

        lrb_match #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .LINE_BYTES(LINE_BYTES)) u_flush_match (
            .rec_vld  (f_vld),
            .rec_base (f_base),
            .rec_tag  (f_tag),
            .q_addr   (q_addr),
            .q_tag    (q_reqno),
            .hit      (flush_hit[p])
        );
    end

    always_comb begin
        q_hit     = 1'b0;
        q_flushed = 1'b0;
        sel_line  = '0;
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (q_pipe == PSEL_W'(p)) begin
                q_hit     = data_hit[p];
                q_flushed = flush_hit[p];
                sel_line  = line_q[p];
            end
        end
        word_idx = q_addr[OFF_W-1:$clog2(lrb_pkg::WORD_BYTES)];
        q_word   = sel_line[word_idx*lrb_pkg::WORD_W +: lrb_pkg::WORD_W];
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !(|data_hit) && !(|flush_hit)); // R1
endmodule

// File: tb/line_return_buffer_bench.sv
`timescale 1ns/1ps
module line_return_buffer_bench;
    localparam int NP = 2;
    localparam int AW = 10;
    localparam int RW = 4;
    localparam int LB = 16;
    localparam int LW = LB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    fill_en = '0;
    logic [NP*AW-1:0] fill_addr = '0;
    logic [NP*RW-1:0] fill_reqno = '0;
    logic [NP*LW-1:0] fill_data = '0;
    logic             snoop_en = 1'b0;
    logic [AW-1:0]    snoop_addr = '0;
    logic             inv_all = 1'b0;
    logic [NP-1:0]    flush_set = '0;
    logic [NP-1:0]    flush_clr = '0;
    logic [NP*AW-1:0] flush_addr = '0;
    logic [NP*RW-1:0] flush_reqno = '0;
    logic [0:0]       q_pipe = '0;
    logic [AW-1:0]    q_addr = '0;
    logic [RW-1:0]    q_reqno = '0;
    logic             q_hit, q_flushed;
    logic [31:0]      q_word;

    int total = 0;
    int fails = 0;

    bit          m_vld [NP];
    int          m_base [NP];
    int          m_tag [NP];
    logic [LW-1:0] m_line [NP];
    bit          m_fvld [NP];
    int          m_fbase [NP];
    int          m_ftag [NP];

    always #2 clk = ~clk;

    line_return_buffer #(.NUM_PIPES(NP), .ADDR_W(AW), .REQ_W(RW), .LINE_BYTES(LB))
    u_line_return_buffer (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_addr(fill_addr),
        .fill_reqno(fill_reqno), .fill_data(fill_data), .snoop_en(snoop_en),
        .snoop_addr(snoop_addr), .inv_all(inv_all), .flush_set(flush_set),
        .flush_clr(flush_clr), .flush_addr(flush_addr), .flush_reqno(flush_reqno),
        .q_pipe(q_pipe), .q_addr(q_addr), .q_reqno(q_reqno),
        .q_hit(q_hit), .q_word(q_word), .q_flushed(q_flushed)
    );

    task automatic chk(bit ok, string msg);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic set_fill(int p, int a, int t, int seed);
        fill_en[p] = 1'b1;
        fill_addr[p*AW +: AW] = AW'(a);
        fill_reqno[p*RW +: RW] = RW'(t);
        for (int k = 0; k < LB/4; k++) begin
            fill_data[p*LW + k*32 +: 32] = 32'(seed * 65536 + k * 4099 + p * 7);
        end
    endtask

    task automatic set_flush(int p, int a, int t);
        flush_set[p] = 1'b1;
        flush_addr[p*AW +: AW] = AW'(a);
        flush_reqno[p*RW +: RW] = RW'(t);
    endtask

    // one clock edge; the model follows the requirements for the held inputs
    task automatic step();
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                m_vld[p] = 0;
                m_fvld[p] = 0;
            end else begin
                if (fill_en[p]) begin
                    m_vld[p]  = 1;
                    m_base[p] = int'(fill_addr[p*AW +: AW]) / LB * LB;
                    m_tag[p]  = int'(fill_reqno[p*RW +: RW]);
                    m_line[p] = fill_data[p*LW +: LW];
                end else if (inv_all ||
                             (snoop_en && m_vld[p] && m_base[p] == int'(snoop_addr) / LB * LB)) begin
                    m_vld[p] = 0;
                end
                if (flush_set[p]) begin
                    m_fvld[p]  = 1;
                    m_fbase[p] = int'(flush_addr[p*AW +: AW]) / LB * LB;
                    m_ftag[p]  = int'(flush_reqno[p*RW +: RW]);
                end else if (flush_clr[p]) begin
                    m_fvld[p] = 0;
                end
            end
        end
        fill_en = '0;
        snoop_en = 1'b0;
        inv_all = 1'b0;
        flush_set = '0;
        flush_clr = '0;
    endtask

    // exhaustive lookup sweep over every pipe, address and request number
    task automatic sweep(string tag);
        for (int p = 0; p < NP; p++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                for (int t = 0; t < (1 << RW); t++) begin
                    bit exp_hit, exp_fl;
                    logic [31:0] exp_word;
                    q_pipe = 1'(p);
                    q_addr = AW'(a);
                    q_reqno = RW'(t);
                    #1;
                    exp_hit = m_vld[p] && m_tag[p] == t && a >= m_base[p] && a < m_base[p] + LB;
                    exp_fl  = m_fvld[p] && m_ftag[p] == t && a >= m_fbase[p] && a < m_fbase[p] + LB;
                    exp_word = 32'(m_line[p] >> (32 * ((a % LB) / 4)));
                    chk(q_hit == exp_hit, $sformatf("%s R3 R9 hit pipe=%0d addr=%0d req=%0d act=%0b exp=%0b",
                        tag, p, a, t, q_hit, exp_hit));
                    chk(q_flushed == exp_fl, $sformatf("%s R8 flushed pipe=%0d addr=%0d req=%0d act=%0b exp=%0b",
                        tag, p, a, t, q_flushed, exp_fl));
                    if (exp_hit) begin
                        chk(q_word == exp_word, $sformatf("%s R4 word pipe=%0d addr=%0d act=%h exp=%h",
                            tag, p, a, q_word, exp_word));
                    end
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        fails++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_vld[p] = 0; m_base[p] = 0; m_tag[p] = 0; m_line[p] = '0;
            m_fvld[p] = 0; m_fbase[p] = 0; m_ftag[p] = 0;
        end
        step(); step();
        rst_n = 1'b1;
        sweep("R1");

        // plain fills on both pipes
        set_fill(0, 'h123, 5, 1);
        set_fill(1, 'h2A7, 9, 2);
        step();
        chk(m_vld[0] && m_base[0] == 'h120, "R2 model base act=bad exp=0x120");
        sweep("R2");

        // snoop to pipe 0's line only; pipe 1 untouched, then unrelated snoop
        snoop_en = 1'b1; snoop_addr = 'h12C;
        step();
        sweep("R5");
        snoop_en = 1'b1; snoop_addr = 'h2B0;
        step();
        sweep("R5");

        // same line in both pipes, one snoop drops both
        set_fill(0, 'h340, 1, 3);
        set_fill(1, 'h34A, 2, 4);
        step();
        snoop_en = 1'b1; snoop_addr = 'h34F;
        step();
        sweep("R5");

        // fill races a snoop to the same line at the top of the space
        set_fill(0, 'h3F8, 15, 5);
        set_fill(1, 'h000, 0, 6);
        snoop_en = 1'b1; snoop_addr = 'h3F0;
        step();
        sweep("R7");

        // invalidate-all with a racing fill on pipe 1; flush records kept
        set_flush(0, 'h055, 3);
        set_flush(1, 'h3FF, 7);
        step();
        sweep("R8");
        inv_all = 1'b1;
        set_fill(1, 'h1E1, 11, 7);
        step();
        sweep("R6");

        // flush clear on pipe 0, set over clear on pipe 1
        flush_clr[0] = 1'b1;
        flush_clr[1] = 1'b1;
        set_flush(1, 'h201, 12);
        step();
        sweep("R8");

        // reset mid-run empties everything
        set_flush(0, 'h0F0, 1);
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        sweep("R1");

        finish_run();
    end
endmodule